// File: doc/BRIEF.md
# Hardware Monitor Register File

This block is the byte-wide register file behind a system hardware monitor. It occupies a 128-byte window in I/O space and gives the host a plain port: an address, a write-data byte, a write strobe, a read strobe, and a registered read-data byte with a valid flag. The window answers only when the enable input is high and the upper address bits equal a base value that is aligned to 128 bytes. The low seven address bits select the register.

Sensor readings reach the block as ready-made 8-bit codes: three temperatures, a set of voltages and a set of fan counts. These codes show up in fixed read slots. Turning analog quantities into codes is done outside the block. The rest of the window is a small stored register set with its own behaviour:
- a per-register write policy and write masking;
- reads of undefined offsets that alias the configuration register at offset 0x40;
- a defined set of power-on values;
- a software reset, triggered by bit 7 of the configuration register, that reloads every default.

Top module: `hwmon_regfile`

## Requirements
- R1: Reads and writes take effect only when `win_en` is 1 and `io_addr[ADDR_W-1:7]` equals `base_addr`. A read outside this gives no `rd_valid`, and a write outside this leaves every register unchanged.
- R2: A read accepted at a rising edge sets `rd_valid` to 1 and puts the selected byte on `rd_data` for the following cycle. In a cycle with no accepted read, `rd_valid` is 0.
- R3: After the external reset, and after the software reset, every stored register reads 0x00 except these: offset 0x17 reads 0x80, 0x3F reads 0xA2, 0x40 reads 0x08, 0x47 reads 0x50 and 0x4B reads 0x15.
- R4: A read of any offset in 0x00–0x0F or 0x50–0x7F returns the current contents of the configuration register at offset 0x40.
- R5: Writes to offsets 0x00–0x0F, 0x3F, 0x41, 0x42, 0x4A and 0x4C–0x7F have no effect on any register.
- R6: A write to offset 0x40 with data bit 7 set reloads every reset value of R3, and the written byte is not stored.
- R7: A write to offset 0x48 stores the data with bit 7 forced to 0.
- R8: Offset 0x20 reads temperature code 0 (`temp_code[7:0]`), offset 0x21 reads temperature code 1, and offset 0x1F reads temperature code 2.
- R9: Offsets 0x22 up to 0x22+N_VOLT-1 read the voltage codes in order, and offsets 0x29 up to 0x29+N_FAN-1 read the fan codes in order. A write to any sensor slot does not change what the slot reads.
- R10: A write to any other offset in 0x10–0x4B stores the full byte. This includes offset 0x40 when bit 7 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | Enables the I/O window |
| base_addr | input | ADDR_W-7 | Upper address bits of the window base |
| io_addr | input | ADDR_W | Host I/O address |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 8 | Write data |
| temp_code | input | 24 | Three temperature codes, code 0 in the low byte |
| volt_code | input | 8*N_VOLT | Voltage codes, code 0 in the low byte |
| fan_code | input | 8*N_FAN | Fan count codes, code 0 in the low byte |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High for one cycle after an accepted read |

## Verification
The stored registers are tried with several data patterns: all-ones, single distinct bytes, and configuration values with bit 7 clear. This separates full-byte storage from masked storage at 0x48 and from the reset-trigger path at 0x40. Alias reads are taken at both ends of each undefined range, before and after the configuration register changes. A stale constant therefore cannot pass for a true alias. Every sensor slot gets its own distinct code, so a swapped temperature order or a shifted voltage or fan slot gives a wrong byte. Disabled-window and wrong-base accesses are each followed by an enabled read-back, so that both decode conditions are checked for their effect on state.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;

  localparam int OFF_W      = 7;
  localparam int STORE_LO   = 'h10;
  localparam int STORE_N    = 64;
  localparam int CFG_OFF    = 'h40;
  localparam int MASK7_OFF  = 'h48;
  localparam int ALIAS_HI   = 'h50;
  localparam int VOLT_OFF   = 'h22;
  localparam int FAN_OFF    = 'h29;
  localparam int SOFT_BIT   = 7;

  typedef logic [7:0] byte_t;

  function automatic byte_t dflt_val(input int off);
    case (off)
      'h17:    return 8'h80;
      'h3F:    return 8'hA2;
      'h40:    return 8'h08;
      'h47:    return 8'h50;
      'h4B:    return 8'h15;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_writable(input int off);
    if (off < STORE_LO) return 1'b0;
    if (off >= 'h4C) return 1'b0;
    if (off == 'h3F || off == 'h41 || off == 'h42 || off == 'h4A) return 1'b0;
    return 1'b1;
  endfunction

  function automatic byte_t store_mask(input int off);
    return (off == MASK7_OFF) ? 8'h7F : 8'hFF;
  endfunction

  function automatic logic is_alias(input logic [OFF_W-1:0] off);
    return (int'(off) < STORE_LO) || (int'(off) >= ALIAS_HI);
  endfunction

endpackage

// File: rtl/hwmon_decode.sv
module hwmon_decode
  import hwmon_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              win_en,
  input  logic [ADDR_W-8:0] base_addr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              wr_stb,
  input  logic              rd_stb,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic [OFF_W-1:0]  off
);

  logic match;

  always_comb begin
    match  = win_en && (io_addr[ADDR_W-1:OFF_W] == base_addr);
    off    = io_addr[OFF_W-1:0];
    wr_hit = match && wr_stb;
    rd_hit = match && rd_stb;
  end

endmodule

// File: rtl/hwmon_store.sv
module hwmon_store
  import hwmon_pkg::*;
#(
  parameter int LO = STORE_LO,
  parameter int N  = STORE_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic             soft_rst,
  output logic [N*8-1:0]   q_flat
);

  for (genvar i = 0; i < N; i++) begin : g_byte
    localparam int OFF = LO + i;
    if (is_writable(OFF)) begin : g_rw
      logic [7:0] q, d;
      logic       en, sel;

      always_comb begin
        sel = wr_en && (int'(wr_off) == OFF);
        en  = soft_rst || sel;
        d   = soft_rst ? dflt_val(OFF) : (wr_data & store_mask(OFF));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= dflt_val(OFF);
        else if (en) q <= d;
      end

      assign q_flat[i*8 +: 8] = q;

      if (OFF == CFG_OFF) begin : g_cfg_chk
        assert_soft_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
          $past(soft_rst) |-> (q == 8'h08));
      end
      if (OFF == MASK7_OFF) begin : g_m7_chk
        assert_bit7_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
          $past(sel && !soft_rst) |-> (q == {1'b0, $past(wr_data[6:0])}));
      end
    end else begin : g_ro
      assign q_flat[i*8 +: 8] = dflt_val(OFF);
    end
  end

endmodule

// File: rtl/hwmon_rdsel.sv
module hwmon_rdsel
  import hwmon_pkg::*;
#(
  parameter int LO     = STORE_LO,
  parameter int N      = STORE_N,
  parameter int N_VOLT = 5,
  parameter int N_FAN  = 2
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [N*8-1:0]    q_flat,
  input  logic [23:0]       temp_code,
  input  logic [N_VOLT*8-1:0] volt_code,
  input  logic [N_FAN*8-1:0]  fan_code,
  output logic [7:0]        rd_byte
);

  localparam int CFG_IDX = CFG_OFF - LO;

  always_comb begin
    rd_byte = q_flat[CFG_IDX*8 +: 8];
    if (!is_alias(off)) rd_byte = q_flat[(int'(off) - LO)*8 +: 8];
    case (int'(off))
      'h1F:    rd_byte = temp_code[23:16];
      'h20:    rd_byte = temp_code[7:0];
      'h21:    rd_byte = temp_code[15:8];
      default: ;
    endcase
    for (int v = 0; v < N_VOLT; v++)
      if (int'(off) == VOLT_OFF + v) rd_byte = volt_code[v*8 +: 8];
    for (int f = 0; f < N_FAN; f++)
      if (int'(off) == FAN_OFF + f) rd_byte = fan_code[f*8 +: 8];
  end

endmodule

// File: rtl/hwmon_regfile.sv
module hwmon_regfile
  import hwmon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_VOLT = 5,
  parameter int N_FAN  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                win_en,
  input  logic [ADDR_W-8:0]   base_addr,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                wr_stb,
  input  logic                rd_stb,
  input  logic [7:0]          wr_data,
  input  logic [23:0]         temp_code,
  input  logic [N_VOLT*8-1:0] volt_code,
  input  logic [N_FAN*8-1:0]  fan_code,
  output logic [7:0]          rd_data,
  output logic                rd_valid
);

  localparam int CFG_IDX = CFG_OFF - STORE_LO;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic             wr_hit, rd_hit, soft_rst, store_we;
  logic [OFF_W-1:0] off;
  logic [STORE_N*8-1:0] q_flat;
  logic [7:0]       rd_byte;

  hwmon_decode #(.ADDR_W(ADDR_W)) u_dec (
    .win_en(win_en), .base_addr(base_addr), .io_addr(io_addr),
    .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .off(off)
  );

  always_comb begin
    soft_rst = wr_hit && (int'(off) == CFG_OFF) && wr_data[SOFT_BIT];
    store_we = wr_hit && !soft_rst;
  end

  hwmon_store #(.LO(STORE_LO), .N(STORE_N)) u_store (
    .clk(clk), .rst_n(rst_int_n), .wr_en(store_we), .wr_off(off),
    .wr_data(wr_data), .soft_rst(soft_rst), .q_flat(q_flat)
  );

  hwmon_rdsel #(.LO(STORE_LO), .N(STORE_N), .N_VOLT(N_VOLT), .N_FAN(N_FAN)) u_rd (
    .off(off), .q_flat(q_flat), .temp_code(temp_code),
    .volt_code(volt_code), .fan_code(fan_code), .rd_byte(rd_byte)
  );

  logic [7:0] rd_data_d;
  logic       rd_valid_d;

  always_comb begin
    rd_valid_d = rd_hit;
    rd_data_d  = rd_hit ? rd_byte : rd_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_data_d;
      rd_valid <= rd_valid_d;
    end
  end

  logic alias_rd;
  assign alias_rd = rd_hit && is_alias(off);

  assert_miss_no_change_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_hit |=> $stable(q_flat));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_hit |=> rd_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_hit |=> !rd_valid);

  assert_alias_cfg_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    alias_rd |=> (rd_data == $past(q_flat[CFG_IDX*8 +: 8])));

endmodule

// File: tb/hwmon_regfile_test.sv
module hwmon_regfile_test;

  localparam int ADDR_W = 16;
  localparam int N_VOLT = 5;
  localparam int N_FAN  = 2;
  localparam logic [ADDR_W-8:0] BASE = 9'h058;

  logic clk = 1'b0;
  logic rst_n, win_en, wr_stb, rd_stb;
  logic [ADDR_W-8:0] base_addr;
  logic [ADDR_W-1:0] io_addr;
  logic [7:0] wr_data, rd_data;
  logic [23:0] temp_code;
  logic [N_VOLT*8-1:0] volt_code;
  logic [N_FAN*8-1:0] fan_code;
  logic rd_valid;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  hwmon_regfile #(.ADDR_W(ADDR_W), .N_VOLT(N_VOLT), .N_FAN(N_FAN)) uut (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .base_addr(base_addr),
    .io_addr(io_addr), .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data),
    .temp_code(temp_code), .volt_code(volt_code), .fan_code(fan_code),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] off, input logic [7:0] d,
                    input logic [ADDR_W-8:0] b = BASE);
    @(negedge clk);
    io_addr = {b, off}; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [6:0] off, output logic [7:0] d, output logic v);
    @(negedge clk);
    io_addr = {BASE, off}; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] off, input logic [7:0] exp);
    logic [7:0] d;
    logic v;
    rd(off, d, v);
    chk({tag, " valid"}, {7'd0, v}, 8'd1);
    chk(tag, d, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_values();
    rd_chk("R3 0x17", 7'h17, 8'h80);
    rd_chk("R3 0x3F", 7'h3F, 8'hA2);
    rd_chk("R3 0x40", 7'h40, 8'h08);
    rd_chk("R3 0x47", 7'h47, 8'h50);
    rd_chk("R3 0x4B", 7'h4B, 8'h15);
    rd_chk("R3 0x10", 7'h10, 8'h00);
    rd_chk("R3 0x48", 7'h48, 8'h00);
  endtask

  task automatic t_alias();
    rd_chk("R4 0x00", 7'h00, 8'h08);
    rd_chk("R4 0x0F", 7'h0F, 8'h08);
    rd_chk("R4 0x50", 7'h50, 8'h08);
    rd_chk("R4 0x7F", 7'h7F, 8'h08);
    wr(7'h40, 8'h23);
    rd_chk("R10 0x40 stored", 7'h40, 8'h23);
    rd_chk("R4 0x60 follows", 7'h60, 8'h23);
    rd_chk("R4 0x03 follows", 7'h03, 8'h23);
  endtask

  task automatic t_ignored();
    wr(7'h3F, 8'h00); wr(7'h41, 8'hFF); wr(7'h42, 8'hFF); wr(7'h4A, 8'hFF);
    wr(7'h4C, 8'hFF); wr(7'h4F, 8'hFF); wr(7'h7E, 8'hFF); wr(7'h05, 8'hFF);
    rd_chk("R5 0x3F", 7'h3F, 8'hA2);
    rd_chk("R5 0x41", 7'h41, 8'h00);
    rd_chk("R5 0x42", 7'h42, 8'h00);
    rd_chk("R5 0x4A", 7'h4A, 8'h00);
    rd_chk("R5 0x4C", 7'h4C, 8'h00);
    rd_chk("R5 0x4F", 7'h4F, 8'h00);
    rd_chk("R5 cfg untouched", 7'h40, 8'h23);
    rd_chk("R5 alias 0x7E", 7'h7E, 8'h23);
  endtask

  task automatic t_store();
    wr(7'h48, 8'hFF);
    rd_chk("R7 0x48 ff", 7'h48, 8'h7F);
    wr(7'h48, 8'h81);
    rd_chk("R7 0x48 81", 7'h48, 8'h01);
    wr(7'h47, 8'h9C);
    rd_chk("R10 0x47", 7'h47, 8'h9C);
    wr(7'h2B, 8'h5A);
    rd_chk("R10 0x2B", 7'h2B, 8'h5A);
    wr(7'h17, 8'hFF);
    rd_chk("R10 0x17", 7'h17, 8'hFF);
  endtask

  task automatic t_soft_reset();
    wr(7'h40, 8'h80);
    rd_chk("R6 0x40", 7'h40, 8'h08);
    rd_chk("R6 0x2B", 7'h2B, 8'h00);
    rd_chk("R6 0x48", 7'h48, 8'h00);
    rd_chk("R6 0x47", 7'h47, 8'h50);
    rd_chk("R6 0x17", 7'h17, 8'h80);
    rd_chk("R6 alias", 7'h55, 8'h08);
  endtask

  task automatic t_sensors();
    temp_code = 24'hC3_B2_A1;
    for (int v = 0; v < N_VOLT; v++) volt_code[v*8 +: 8] = 8'h60 + 8'(v);
    for (int f = 0; f < N_FAN; f++)  fan_code[f*8 +: 8]  = 8'hE0 + 8'(f);
    rd_chk("R8 0x20", 7'h20, 8'hA1);
    rd_chk("R8 0x21", 7'h21, 8'hB2);
    rd_chk("R8 0x1F", 7'h1F, 8'hC3);
    for (int v = 0; v < N_VOLT; v++)
      rd_chk("R9 volt", 7'(7'h22 + v), 8'h60 + 8'(v));
    for (int f = 0; f < N_FAN; f++)
      rd_chk("R9 fan", 7'(7'h29 + f), 8'hE0 + 8'(f));
    wr(7'h20, 8'h11); wr(7'h23, 8'h11); wr(7'h2A, 8'h11);
    rd_chk("R9 temp slot after write", 7'h20, 8'hA1);
    rd_chk("R9 volt slot after write", 7'h23, 8'h61);
    rd_chk("R9 fan slot after write", 7'h2A, 8'hE1);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    logic v;
    win_en = 1'b0;
    rd(7'h2C, d, v);
    chk("R1 disabled no valid", {7'd0, v}, 8'd0);
    wr(7'h2C, 8'h66);
    win_en = 1'b1;
    wr(7'h2D, 8'h77, BASE + 9'd1);
    rd_chk("R1 disabled write", 7'h2C, 8'h00);
    rd_chk("R1 base miss write", 7'h2D, 8'h00);
    @(negedge clk);
    chk("R2 idle valid low", {7'd0, rd_valid}, 8'd0);
    wr(7'h2C, 8'h3E);
    rd_chk("R10 0x2C after enable", 7'h2C, 8'h3E);
  endtask

  task automatic t_ext_reset();
    wr(7'h40, 8'h11);
    wr(7'h2E, 8'h44);
    do_reset();
    rd_chk("R3 ext 0x40", 7'h40, 8'h08);
    rd_chk("R3 ext 0x2E", 7'h2E, 8'h00);
    rd_chk("R3 ext 0x2C", 7'h2C, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; win_en = 1'b1; base_addr = BASE; io_addr = '0;
    wr_stb = 1'b0; rd_stb = 1'b0; wr_data = '0;
    temp_code = '0; volt_code = '0; fan_code = '0;
    do_reset();
    chk("R2 reset valid low", {7'd0, rd_valid}, 8'd0);
    t_reset_values();
    t_alias();
    t_ignored();
    t_store();
    t_soft_reset();
    t_sensors();
    t_decode();
    t_ext_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule